// File: doc/BRIEF.md
# Two-Pass 8x8 Integer Inverse Transform

This block turns an 8x8 tile of signed 16-bit transform coefficients into an 8x8 tile of signed 16-bit residuals. It uses a separable integer transform. A vertical pass works on each coefficient column and stores its rounded, clamped results transposed into a second tile. A horizontal pass then reads that tile column by column and produces the residual rows in row-major order. Each 8-point pass splits into two halves. The even half is a 4-point butterfly on the even-indexed inputs. The odd half is a dot product of the odd-indexed inputs with four constants.

Rows stream in one per cycle over a valid/ready handshake and leave one per cycle over a second handshake. A one-cycle completion pulse follows the last output row. A flag on the first row selects a DC shortcut. In that mode only the first row is taken, and its lowest lane fills all 64 outputs. A second flag on the first row selects 8-bit or 10-bit sample depth, which sets the second-pass shift.

The controller has four named states:
- ST_LOAD accepts input rows.
- ST_COLPASS runs the vertical pass, one column per cycle.
- ST_ROWOUT emits transformed rows.
- ST_DCOUT emits the DC fill.

Its transitions are:
- load_to_col: the eighth row is accepted in normal mode.
- load_to_dc: the first row carries the DC flag.
- col_to_row: after the eighth column.
- row_to_load: the eighth output row is accepted.
- dc_to_load: the eighth fill row is accepted.

Top module: `idct8_core`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and done is 0.
- R2: When in_dc is 0 on the first row, exactly eight rows are accepted, and in_ready is 0 in the cycle after the eighth acceptance. in_ready stays 0 until the block completes.
- R3: Each output equals the two-pass transform. For one pass with inputs s0..s7:
  - e0 = 64*s0 + 64*s4 and e1 = 64*s0 - 64*s4.
  - o0 = 83*s2 + 36*s6 and o1 = 36*s2 - 83*s6.
  - E = {e0+o0, e1+o1, e1-o1, e0-o0}.
  - O0 = 89*s1 + 75*s3 + 50*s5 + 18*s7.
  - O1 = 75*s1 - 18*s3 - 89*s5 - 50*s7.
  - O2 = 50*s1 - 89*s3 + 18*s5 + 75*s7.
  - O3 = 18*s1 - 50*s3 + 75*s5 - 89*s7.
  - Output k is E[k]+O[k] and output 7-k is E[k]-O[k].
  - The vertical pass rounds by adding 64 and arithmetic-shifting right by 7.
- R4: With in_hi_depth at 0 the horizontal pass shift is 12; with 1 it is 10. In both cases half of 2^shift is added first. in_hi_depth is sampled only with the first row of a tile.
- R5: Both passes clamp their rounded sums to [-32768, 32767]. All arithmetic before the clamp is done at full precision.
- R6: When in_dc is 1 with the first row, only that row is accepted. Every output sample then equals ((d+1)>>>1 + 32)>>>6, where d is lane 0 of that row and the shifts are arithmetic.
- R7: Lane k of in_row and out_row sits at bits [16k+15:16k] and holds column k. Output rows leave in order, row 0 first.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_row is unchanged in the next cycle.
- R9: done is a single-cycle pulse in the cycle after the eighth output row is accepted. in_ready is 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input row is valid |
| in_ready | output | 1 | Block accepts an input row |
| in_dc | input | 1 | DC shortcut select, sampled with the first row |
| in_hi_depth | input | 1 | 1 selects 10-bit depth, 0 selects 8-bit; sampled with the first row |
| in_row | input | 128 | Eight signed 16-bit coefficients, lane k = column k |
| out_valid | output | 1 | Output row is valid |
| out_ready | input | 1 | Consumer takes the output row |
| out_row | output | 128 | Eight signed 16-bit residuals, lane k = column k |
| done | output | 1 | Pulse after the last row of a tile |

## Verification
The assertions assume the consumer never needs an output row withdrawn once it has been offered. They also assume in_dc is meaningful only on the first row of a tile, which the checker identifies through the row counter.

The bench drives in_dc only on the first row and holds in_valid until each row is taken. It keeps out_ready under a repeating stall pattern that never blocks for long. It also changes in_hi_depth after the first row so that the sampling rule is exercised, not avoided.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

    localparam int N      = 8;
    localparam int SAMP_W = 16;
    localparam int ACC_W  = 32;
    localparam int ROW_W  = N * SAMP_W;
    localparam int IDX_W  = $clog2(N);
    localparam int SH_W   = 5;

    typedef enum logic [1:0] {
        ST_LOAD,
        ST_COLPASS,
        ST_ROWOUT,
        ST_DCOUT
    } phase_e;

    // rounding right shift followed by clamp to the sample range
    function automatic logic [SAMP_W-1:0] rnd_sat(input logic signed [ACC_W-1:0] v,
                                                  input logic [SH_W-1:0] sh);
        logic signed [ACC_W:0] w;
        logic signed [ACC_W:0] hi_lim;
        logic signed [ACC_W:0] lo_lim;
        hi_lim = (($signed({{ACC_W{1'b0}}, 1'b1})) <<< (SAMP_W - 1)) - 1;
        lo_lim = -hi_lim - 1;
        w = $signed({v[ACC_W-1], v}) + ($signed({{ACC_W{1'b0}}, 1'b1}) <<< (sh - 1'b1));
        w = w >>> sh;
        if (w > hi_lim) begin
            w = hi_lim;
        end else if (w < lo_lim) begin
            w = lo_lim;
        end
        return w[SAMP_W-1:0];
    endfunction

    // fill value of the DC shortcut
    function automatic logic [SAMP_W-1:0] dc_fill(input logic [SAMP_W-1:0] dc);
        logic signed [SAMP_W+1:0] t;
        t = $signed({{2{dc[SAMP_W-1]}}, dc}) + 1;
        t = t >>> 1;
        t = t + 32;
        t = t >>> 6;
        return t[SAMP_W-1:0];
    endfunction

endpackage

// File: rtl/idct8_butterfly.sv
module idct8_butterfly
    import idct8_pkg::*;
(
    input  logic [ROW_W-1:0] vec_in,
    input  logic [SH_W-1:0]  shamt,
    output logic [ROW_W-1:0] vec_out
);

    logic signed [ACC_W-1:0] s    [N];
    logic signed [ACC_W-1:0] sums [N];
    logic signed [ACC_W-1:0] ev0, ev1, od0, od1;
    logic signed [ACC_W-1:0] big_e [4];
    logic signed [ACC_W-1:0] big_o [4];

    for (genvar k = 0; k < N; k++) begin : g_ext
        assign s[k] = {{(ACC_W-SAMP_W){vec_in[k*SAMP_W+SAMP_W-1]}}, vec_in[k*SAMP_W +: SAMP_W]};
    end

    always_comb begin
        ev0 = (s[0] <<< 6) + (s[4] <<< 6);
        ev1 = (s[0] <<< 6) - (s[4] <<< 6);
        od0 = 32'sd83 * s[2] + 32'sd36 * s[6];
        od1 = 32'sd36 * s[2] - 32'sd83 * s[6];
        big_e[0] = ev0 + od0;
        big_e[1] = ev1 + od1;
        big_e[2] = ev1 - od1;
        big_e[3] = ev0 - od0;
        big_o[0] = 32'sd89 * s[1] + 32'sd75 * s[3] + 32'sd50 * s[5] + 32'sd18 * s[7];
        big_o[1] = 32'sd75 * s[1] - 32'sd18 * s[3] - 32'sd89 * s[5] - 32'sd50 * s[7];
        big_o[2] = 32'sd50 * s[1] - 32'sd89 * s[3] + 32'sd18 * s[5] + 32'sd75 * s[7];
        big_o[3] = 32'sd18 * s[1] - 32'sd50 * s[3] + 32'sd75 * s[5] - 32'sd89 * s[7];
    end

    for (genvar k = 0; k < N/2; k++) begin : g_fold
        assign sums[k]     = big_e[k] + big_o[k];
        assign sums[N-1-k] = big_e[k] - big_o[k];
    end

    for (genvar k = 0; k < N; k++) begin : g_narrow
        assign vec_out[k*SAMP_W +: SAMP_W] = rnd_sat(sums[k], shamt);
    end

endmodule

// File: rtl/idct8_tile.sv
module idct8_tile #(
    parameter int N = 8,
    parameter int W = 16
) (
    input  logic                   clk,
    input  logic                   wr_en,
    input  logic [$clog2(N)-1:0]   wr_idx,
    input  logic [N*W-1:0]         wr_row,
    input  logic [$clog2(N)-1:0]   rd_idx,
    output logic [N*W-1:0]         rd_col
);

    logic [N*W-1:0] rows_q [N];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            rows_q[wr_idx] <= wr_row;
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_col
        assign rd_col[k*W +: W] = rows_q[k][rd_idx*W +: W];
    end

endmodule

// File: rtl/idct8_core.sv
module idct8_core
    import idct8_pkg::*;
#(
    parameter int PASS1_SHIFT = 7,
    parameter int DEPTH_REF   = 20,
    parameter int LO_BITS     = 8,
    parameter int HI_BITS     = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_dc,
    input  logic             in_hi_depth,
    input  logic [ROW_W-1:0] in_row,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [ROW_W-1:0] out_row,
    output logic             done
);

    localparam logic [SH_W-1:0]  SH1    = SH_W'(PASS1_SHIFT);
    localparam logic [SH_W-1:0]  SH2_LO = SH_W'(DEPTH_REF - LO_BITS);
    localparam logic [SH_W-1:0]  SH2_HI = SH_W'(DEPTH_REF - HI_BITS);
    localparam logic [IDX_W-1:0] LAST   = IDX_W'(N - 1);

    phase_e             state_q, state_d;
    logic [IDX_W-1:0]   cnt_q;
    logic               hi_q;
    logic [SAMP_W-1:0]  fill_q;
    logic               done_q;

    logic               in_fire, out_fire, cnt_last;
    logic               b_wr;
    logic [ROW_W-1:0]   a_col, b_col, p1_row, p2_row;
    logic [SH_W-1:0]    sh2;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;
    assign cnt_last = (cnt_q == LAST);
    assign sh2      = hi_q ? SH2_HI : SH2_LO;

    idct8_tile #(.N(N), .W(SAMP_W)) u_coef_tile (
        .clk    (clk),
        .wr_en  (in_fire),
        .wr_idx (cnt_q),
        .wr_row (in_row),
        .rd_idx (cnt_q),
        .rd_col (a_col)
    );

    idct8_butterfly u_vert (
        .vec_in  (a_col),
        .shamt   (SH1),
        .vec_out (p1_row)
    );

    idct8_tile #(.N(N), .W(SAMP_W)) u_mid_tile (
        .clk    (clk),
        .wr_en  (b_wr),
        .wr_idx (cnt_q),
        .wr_row (p1_row),
        .rd_idx (cnt_q),
        .rd_col (b_col)
    );

    idct8_butterfly u_horz (
        .vec_in  (b_col),
        .shamt   (sh2),
        .vec_out (p2_row)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: begin
                if (in_fire && cnt_q == '0 && in_dc) begin
                    state_d = ST_DCOUT;              // load_to_dc
                end else if (in_fire && cnt_last) begin
                    state_d = ST_COLPASS;            // load_to_col
                end
            end
            ST_COLPASS: begin
                if (cnt_last) state_d = ST_ROWOUT;   // col_to_row
            end
            ST_ROWOUT: begin
                if (out_fire && cnt_last) state_d = ST_LOAD;  // row_to_load
            end
            ST_DCOUT: begin
                if (out_fire && cnt_last) state_d = ST_LOAD;  // dc_to_load
            end
            default: state_d = ST_LOAD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            cnt_q   <= '0;
            hi_q    <= 1'b0;
            fill_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= 1'b0;
            unique case (state_q)
                ST_LOAD: begin
                    if (in_fire) begin
                        if (cnt_q == '0) begin
                            hi_q   <= in_hi_depth;
                            fill_q <= dc_fill(in_row[SAMP_W-1:0]);
                        end
                        if (cnt_q == '0 && in_dc) begin
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_COLPASS: begin
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_ROWOUT, ST_DCOUT: begin
                    if (out_fire) begin
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_last) done_q <= 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        b_wr      = 1'b0;
        out_row   = p2_row;
        unique case (state_q)
            ST_LOAD:    in_ready  = 1'b1;
            ST_COLPASS: b_wr      = 1'b1;
            ST_ROWOUT:  out_valid = 1'b1;
            ST_DCOUT: begin
                out_valid = 1'b1;
                out_row   = {N{fill_q}};
            end
            default: in_ready = 1'b0;
        endcase
    end

    assign done = done_q;

endmodule

// File: rtl/idct8_core_chk.sv
module idct8_core_chk
    import idct8_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_dc,
    input logic             out_valid,
    input logic             out_ready,
    input logic [ROW_W-1:0] out_row,
    input logic             done,
    input logic [IDX_W-1:0] row_idx
);

    // R2
    eighth_row_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_dc && row_idx == IDX_W'(N-1)) |=> !in_ready);

    // R6
    dc_row_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_dc && row_idx == '0) |=> (out_valid && !in_ready));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_row)));

    // R9
    done_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_valid && out_ready) && in_ready));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

endmodule

bind idct8_core idct8_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_dc     (in_dc),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_row   (out_row),
    .done      (done),
    .row_idx   (cnt_q)
);

// File: tb/idct8_core_tb_top.sv
`timescale 1ns/1ps
module idct8_core_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_dc = 1'b0;
    logic         in_hi_depth = 1'b0;
    logic [127:0] in_row = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_row;
    logic         done;

    always #2.5 clk = ~clk;

    idct8_core dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_dc       (in_dc),
        .in_hi_depth (in_hi_depth),
        .in_row      (in_row),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_row     (out_row),
        .done        (done)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int mtx [8][8];
    int coef [8][8];
    logic [127:0] exp_q [$];
    string        tag_q [$];

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int rsh(input int v, input int sh);
        return sat16((v + (1 << (sh - 1))) >>> sh);
    endfunction

    task automatic set_row(input int k, input int a0, input int a1, input int a2, input int a3,
                           input int a4, input int a5, input int a6, input int a7);
        mtx[k][0] = a0; mtx[k][1] = a1; mtx[k][2] = a2; mtx[k][3] = a3;
        mtx[k][4] = a4; mtx[k][5] = a5; mtx[k][6] = a6; mtx[k][7] = a7;
    endtask

    // basis rows: mtx[k][n] weights coefficient k into output n
    task automatic init_mtx();
        set_row(0, 64, 64, 64, 64, 64, 64, 64, 64);
        set_row(1, 89, 75, 50, 18, -18, -50, -75, -89);
        set_row(2, 83, 36, -36, -83, -83, -36, 36, 83);
        set_row(3, 75, -18, -89, -50, 50, 89, 18, -75);
        set_row(4, 64, -64, -64, 64, 64, -64, -64, 64);
        set_row(5, 50, -89, 18, 75, -75, -18, 89, -50);
        set_row(6, 36, -83, 83, -36, -36, 83, -83, 36);
        set_row(7, 18, -50, 75, -89, 89, -75, 50, -18);
    endtask

    task automatic push_expected(input bit dc, input bit hi, input string tag);
        int tmp [8][8];
        logic [127:0] r;
        if (dc) begin
            int f;
            f = (((coef[0][0] + 1) >>> 1) + 32) >>> 6;
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) r[j*16 +: 16] = 16'(f);
                exp_q.push_back(r);
                tag_q.push_back(tag);
            end
        end else begin
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++) begin
                    int acc = 0;
                    for (int k = 0; k < 8; k++) acc += mtx[k][i] * coef[k][j];
                    tmp[i][j] = rsh(acc, 7);
                end
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    int acc = 0;
                    for (int k = 0; k < 8; k++) acc += mtx[k][j] * tmp[i][k];
                    r[j*16 +: 16] = 16'(rsh(acc, hi ? 10 : 12));
                end
                exp_q.push_back(r);
                tag_q.push_back(tag);
            end
        end
    endtask

    task automatic send_block(input bit dc, input bit hi, input bit hi_late, input string tag);
        push_expected(dc, hi, tag);
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            in_valid    = 1'b1;
            in_dc       = (r == 0) ? dc : 1'b0;
            in_hi_depth = (r == 0) ? hi : hi_late;
            for (int c = 0; c < 8; c++) in_row[c*16 +: 16] = 16'(coef[r][c]);
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            if (dc) break;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_dc    = 1'b0;
        // R2 / R6: no further rows taken right after the tile is in
        chk(in_ready == 1'b0, dc ? "R6 in_ready after dc row" : "R2 in_ready after 8 rows",
            {127'b0, in_ready}, 128'b0);
    endtask

    task automatic fill_pattern(input int seed, input int scale);
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++)
                coef[r][c] = ((r * r * 29 + c * 71 + seed * 113) % 401 - 200) * scale;
    endtask

    // monitor: pops expected rows as the design produces them
    initial begin
        int cyc = 0;
        int hs = 0;
        bit pend_done = 1'b0;
        bit prev_stall = 1'b0;
        logic [127:0] prev_row = '0;
        wait (rst_n);
        forever begin
            @(negedge clk);
            out_ready = (cyc % 5 != 2) && (cyc % 7 != 3);
            cyc++;
            #1;
            if (pend_done) begin
                // R9
                chk(done && in_ready, "R9 done pulse with in_ready", {126'b0, done, in_ready}, 128'd3);
                pend_done = 1'b0;
            end
            if (prev_stall) begin
                // R8
                chk(out_valid && out_row == prev_row, "R8 held under stall", out_row, prev_row);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected row", out_row, '0);
                end else begin
                    logic [127:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(out_row == e, t, out_row, e);
                end
                hs++;
                if (hs % 8 == 0) pend_done = 1'b1;
            end
            prev_stall = out_valid && !out_ready;
            prev_row   = out_row;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        init_mtx();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1
        chk(in_ready == 1'b1, "R1 in_ready after reset", {127'b0, in_ready}, 128'd1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", {127'b0, out_valid}, 128'd0);
        chk(done == 1'b0, "R1 done after reset", {127'b0, done}, 128'd0);

        // R7: sparse tile exposes lane and row placement
        for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) coef[r][c] = 0;
        coef[0][1] = 256;
        coef[2][0] = -128;
        coef[5][6] = 300;
        send_block(1'b0, 1'b0, 1'b0, "R7 lane and row order");

        // R3: dense patterns, 8-bit depth
        fill_pattern(1, 20);
        send_block(1'b0, 1'b0, 1'b0, "R3 transform depth8");
        fill_pattern(5, 3);
        send_block(1'b0, 1'b0, 1'b1, "R3 transform small values");

        // R4: 10-bit depth and late depth changes ignored
        fill_pattern(2, 20);
        send_block(1'b0, 1'b1, 1'b0, "R4 depth10 sampled on first row");
        fill_pattern(3, 20);
        send_block(1'b0, 1'b0, 1'b1, "R4 depth8 sampled on first row");

        // R5: saturation in both passes
        for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) coef[r][c] = 32767;
        send_block(1'b0, 1'b0, 1'b0, "R5 clamp all max");
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) coef[r][c] = ((r + c) % 2 == 0) ? 32767 : -32768;
        send_block(1'b0, 1'b1, 1'b1, "R5 clamp checkerboard");
        for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) coef[r][c] = -32768;
        send_block(1'b0, 1'b1, 1'b0, "R5 clamp all min");

        // R6: DC shortcut, other lanes of row 0 ignored
        for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) coef[r][c] = 1000 * c - 3000;
        coef[0][0] = 100;
        send_block(1'b1, 1'b0, 1'b0, "R6 dc fill 100");
        coef[0][0] = -1;
        send_block(1'b1, 1'b1, 1'b0, "R6 dc fill -1");
        coef[0][0] = 32767;
        send_block(1'b1, 1'b0, 1'b0, "R6 dc fill max");
        coef[0][0] = -32768;
        send_block(1'b1, 1'b0, 1'b0, "R6 dc fill min");

        // R3 after DC: normal path still intact
        fill_pattern(7, 40);
        send_block(1'b0, 1'b0, 1'b0, "R3 transform after dc");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule